// File: doc/BRIEF.md
# YCrCb Picture Bus Formatter

This block turns decoded luminance and the two colour-difference signals (R−Y and B−Y), all carried as signed fixed point with a fractional part, into the 8-bit words of a picture bus. Luma is scaled by 224, lifted by 16 and limited to the studio range. Each colour difference is multiplied by its own programmable weight, then by 224, and limited to ±112. It is then presented either around a mid-code of 128 (offset binary) or as a signed byte (two's complement).

A sample is accepted in any cycle in which `in_valid_i` is high. Its three output words appear together two clocks later with `out_valid_o`. The two weights are unsigned values with 8 fractional bits, so 256 means 1.0. They reset to 183 for Cr and 144 for Cb, which are the studio colour-difference coefficients, and each can be rewritten on its own. The format select is a level input. It is latched with each sample, so it can change freely between samples.

Top module: `pbf_picbus_fmt`

## Requirements
- R1: For a sample with signed luma L (10 fractional bits), `y_o` equals floor((224·L + 16·1024 + 512) / 1024), limited to the range 16..235.
- R2: In offset mode (`fmt_twos_i`=0), `cr_o` equals 128 + C. C is floor((224·Gcr·D + 2^17) / 2^18), limited to −112..+112, where D is the signed R−Y input (10 fractional bits) and Gcr is the Cr weight (8 fractional bits). In this mode the output lies in 16..240.
- R3: `cb_o` follows the rule of R2, applied to the B−Y input and the Cb weight.
- R4: After reset the Cr weight is 183 and the Cb weight is 144. With R−Y = B−Y = 512 (0.5), Cr = 208 and Cb = 191.
- R5: A pulse on `cr_gain_we_i` loads `gain_wdata_i` into the Cr weight only, and a pulse on `cb_gain_we_i` loads it into the Cb weight only. A weight loaded at a clock edge applies to samples accepted after that edge.
- R6: In two's complement mode (`fmt_twos_i`=1), `cr_o` and `cb_o` carry C itself as a signed byte in −112..+112, with no 128 added.
- R7: The format used for a sample is the value of `fmt_twos_i` in the cycle that sample is accepted. Back-to-back samples in different modes each come out in their own mode.
- R8: `out_valid_o` is `in_valid_i` delayed by exactly two clocks. The data of a sample appears in the same cycle as its valid.
- R9: Reset clears `out_valid_o`, `y_o`, `cr_o` and `cb_o` to zero. The output words keep their last values while no new sample emerges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample present |
| luma_i | input | IN_W | Signed luma, IN_FRAC fractional bits |
| rmy_i | input | IN_W | Signed R−Y, IN_FRAC fractional bits |
| bmy_i | input | IN_W | Signed B−Y, IN_FRAC fractional bits |
| fmt_twos_i | input | 1 | 1 selects two's complement chroma, 0 selects offset binary |
| cr_gain_we_i | input | 1 | Load Cr weight |
| cb_gain_we_i | input | 1 | Load Cb weight |
| gain_wdata_i | input | GAIN_W | Weight value, GAIN_FRAC fractional bits |
| out_valid_o | output | 1 | Output words present |
| y_o | output | 8 | Luma word |
| cr_o | output | 8 | Cr word |
| cb_o | output | 8 | Cb word |

## Verification
The assertions assume that `in_valid_i` and `fmt_twos_i` are clean levels that are sampled once per clock from the first edge after reset. On that basis the checker compares output validity and the chroma range against copies of those inputs delayed by two cycles. The stimulus drives every input only on the falling edge, so each value is settled before the rising edge that samples it. It holds data inputs to their declared signed width, including both extreme codes, so that the clamps are reached without relying on wrap-around. Weight writes and format changes are mixed into the random stream at arbitrary points, including cycles that also accept a sample.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
    // Scale of the picture bus: 219/224 style studio range uses 224 here.
    localparam int SCALE        = 224;
    localparam int SCALE_W      = 8;
    localparam int Y_FLOOR      = 16;
    localparam int Y_CEIL       = 235;
    localparam int C_SPAN       = 112;
    localparam int C_MID        = 128;
    localparam int OUT_W        = 8;
    // Weight reset values: round(0.713*256), round(0.564*256).
    localparam int CR_GAIN_DFLT = 183;
    localparam int CB_GAIN_DFLT = 144;
endpackage

// File: rtl/pbf_luma_lane.sv
module pbf_luma_lane
    import pbf_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int IN_FRAC = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take_i,
    input  logic                   emit_i,
    input  logic signed [IN_W-1:0] luma_i,
    output logic [OUT_W-1:0]       y_o
);
    localparam int P1_W = IN_W + SCALE_W + 1;
    localparam int P2_W = P1_W + 2;
    localparam logic signed [P1_W-1:0] SCALE_S = P1_W'(SCALE);
    localparam logic signed [P2_W-1:0] BIAS    =
        P2_W'((Y_FLOOR << IN_FRAC) + (1 << (IN_FRAC - 1)));
    localparam logic signed [P2_W-1:0] LO      = P2_W'(Y_FLOOR);
    localparam logic signed [P2_W-1:0] HI      = P2_W'(Y_CEIL);

    typedef struct packed {
        logic [P1_W-1:0]  prod;
        logic [OUT_W-1:0] y;
    } luma_st_t;

    luma_st_t s_d, s_q;
    logic signed [P1_W-1:0] ext_d;
    logic signed [P2_W-1:0] biased_d;
    logic signed [P2_W-1:0] rnd_d;

    always_comb begin
        s_d      = s_q;
        ext_d    = {{(SCALE_W + 1){luma_i[IN_W-1]}}, luma_i};
        biased_d = $signed({{2{s_q.prod[P1_W-1]}}, s_q.prod}) + BIAS;
        rnd_d    = biased_d >>> IN_FRAC;
        if (take_i) begin
            s_d.prod = ext_d * SCALE_S;
        end
        if (emit_i) begin
            if (rnd_d < LO) begin
                s_d.y = OUT_W'(Y_FLOOR);
            end else if (rnd_d > HI) begin
                s_d.y = OUT_W'(Y_CEIL);
            end else begin
                s_d.y = rnd_d[OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign y_o = s_q.y;
endmodule

// File: rtl/pbf_chroma_lane.sv
module pbf_chroma_lane
    import pbf_pkg::*;
#(
    parameter int IN_W      = 12,
    parameter int IN_FRAC   = 10,
    parameter int GAIN_W    = 9,
    parameter int GAIN_FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take_i,
    input  logic                   emit_i,
    input  logic signed [IN_W-1:0] diff_i,
    input  logic [GAIN_W-1:0]      gain_i,
    input  logic                   twos_i,
    output logic [OUT_W-1:0]       c_o
);
    localparam int P1_W  = IN_W + GAIN_W + 1;
    localparam int P2_W  = P1_W + SCALE_W + 1;
    localparam int SHIFT = IN_FRAC + GAIN_FRAC;
    localparam logic signed [P2_W-1:0] SCALE_S = P2_W'(SCALE);
    localparam logic signed [P2_W-1:0] HALF    = P2_W'(1) <<< (SHIFT - 1);
    localparam logic signed [P2_W-1:0] LIM_HI  = P2_W'(C_SPAN);
    localparam logic signed [P2_W-1:0] LIM_LO  = -P2_W'(C_SPAN);

    typedef struct packed {
        logic [P1_W-1:0]  prod;
        logic             twos;
        logic [OUT_W-1:0] c;
    } chroma_st_t;

    chroma_st_t s_d, s_q;
    logic signed [P1_W-1:0] ext_d;
    logic signed [P1_W-1:0] gain_ext_d;
    logic signed [P2_W-1:0] wide_d;
    logic signed [P2_W-1:0] rnd_d;
    logic [OUT_W-1:0]       lim_d;

    always_comb begin
        s_d        = s_q;
        ext_d      = {{(GAIN_W + 1){diff_i[IN_W-1]}}, diff_i};
        gain_ext_d = {{(IN_W + 1){1'b0}}, gain_i};
        wide_d     = $signed({{(SCALE_W + 1){s_q.prod[P1_W-1]}}, s_q.prod}) * SCALE_S;
        rnd_d      = (wide_d + HALF) >>> SHIFT;
        if (rnd_d > LIM_HI) begin
            lim_d = OUT_W'(C_SPAN);
        end else if (rnd_d < LIM_LO) begin
            lim_d = OUT_W'(-C_SPAN);
        end else begin
            lim_d = rnd_d[OUT_W-1:0];
        end
        if (take_i) begin
            s_d.prod = ext_d * gain_ext_d;
            s_d.twos = twos_i;
        end
        if (emit_i) begin
            s_d.c = s_q.twos ? lim_d : lim_d + OUT_W'(C_MID);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign c_o = s_q.c;
endmodule

// File: rtl/pbf_picbus_fmt.sv
module pbf_picbus_fmt
    import pbf_pkg::*;
#(
    parameter int IN_W        = 12,
    parameter int IN_FRAC     = 10,
    parameter int GAIN_W      = 9,
    parameter int GAIN_FRAC   = 8,
    parameter int CR_GAIN_RST = CR_GAIN_DFLT,
    parameter int CB_GAIN_RST = CB_GAIN_DFLT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid_i,
    input  logic signed [IN_W-1:0] luma_i,
    input  logic signed [IN_W-1:0] rmy_i,
    input  logic signed [IN_W-1:0] bmy_i,
    input  logic                   fmt_twos_i,
    input  logic                   cr_gain_we_i,
    input  logic                   cb_gain_we_i,
    input  logic [GAIN_W-1:0]      gain_wdata_i,
    output logic                   out_valid_o,
    output logic [7:0]             y_o,
    output logic [7:0]             cr_o,
    output logic [7:0]             cb_o
);
    localparam int LANES = 2;

    typedef struct packed {
        logic [GAIN_W-1:0] cr_gain;
        logic [GAIN_W-1:0] cb_gain;
        logic              v1;
        logic              v2;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        c_d.v1 = in_valid_i;
        c_d.v2 = c_q.v1;
        if (cr_gain_we_i) begin
            c_d.cr_gain = gain_wdata_i;
        end
        if (cb_gain_we_i) begin
            c_d.cb_gain = gain_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cr_gain <= GAIN_W'(CR_GAIN_RST);
            c_q.cb_gain <= GAIN_W'(CB_GAIN_RST);
            c_q.v1      <= 1'b0;
            c_q.v2      <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    pbf_luma_lane #(
        .IN_W    (IN_W),
        .IN_FRAC (IN_FRAC)
    ) u_luma (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (in_valid_i),
        .emit_i (c_q.v1),
        .luma_i (luma_i),
        .y_o    (y_o)
    );

    logic signed [IN_W-1:0] diff_a [LANES];
    logic [GAIN_W-1:0]      gain_a [LANES];
    logic [OUT_W-1:0]       word_a [LANES];

    assign diff_a[0] = rmy_i;
    assign diff_a[1] = bmy_i;
    assign gain_a[0] = c_q.cr_gain;
    assign gain_a[1] = c_q.cb_gain;

    for (genvar g = 0; g < LANES; g++) begin : g_chroma
        pbf_chroma_lane #(
            .IN_W      (IN_W),
            .IN_FRAC   (IN_FRAC),
            .GAIN_W    (GAIN_W),
            .GAIN_FRAC (GAIN_FRAC)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (in_valid_i),
            .emit_i (c_q.v1),
            .diff_i (diff_a[g]),
            .gain_i (gain_a[g]),
            .twos_i (fmt_twos_i),
            .c_o    (word_a[g])
        );
    end

    assign cr_o        = word_a[0];
    assign cb_o        = word_a[1];
    assign out_valid_o = c_q.v2;
endmodule

// File: rtl/pbf_picbus_fmt_chk.sv
module pbf_picbus_fmt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid_i,
    input logic       fmt_twos_i,
    input logic       out_valid_o,
    input logic [7:0] y_o,
    input logic [7:0] cr_o,
    input logic [7:0] cb_o
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign warm = (age_q >= 2'd2);

    a_r8_valid_delay : assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid_o == $past(in_valid_i, 2)));

    a_r1_luma_range : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (y_o >= 8'd16 && y_o <= 8'd235));

    a_r2_offset_range : assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid_o && !$past(fmt_twos_i, 2)) |->
        (cr_o >= 8'd16 && cr_o <= 8'd240 && cb_o >= 8'd16 && cb_o <= 8'd240));

    a_r6_twos_range : assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid_o && $past(fmt_twos_i, 2)) |->
        ($signed(cr_o) >= -8'sd112 && $signed(cr_o) <= 8'sd112 &&
         $signed(cb_o) >= -8'sd112 && $signed(cb_o) <= 8'sd112));

    a_r9_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(in_valid_i, 2)) |->
        ($stable(y_o) && $stable(cr_o) && $stable(cb_o)));
endmodule

bind pbf_picbus_fmt pbf_picbus_fmt_chk u_chk (.*);

// File: tb/pbf_picbus_fmt_tb.sv
`timescale 1ns/1ps
module pbf_picbus_fmt_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] luma = '0;
    logic signed [11:0] rmy = '0;
    logic signed [11:0] bmy = '0;
    logic              fmt = 1'b0;
    logic              cr_we = 1'b0;
    logic              cb_we = 1'b0;
    logic [8:0]        wdata = '0;
    logic              out_valid;
    logic [7:0]        y_o, cr_o, cb_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pbf_picbus_fmt u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid_i   (in_valid),
        .luma_i       (luma),
        .rmy_i        (rmy),
        .bmy_i        (bmy),
        .fmt_twos_i   (fmt),
        .cr_gain_we_i (cr_we),
        .cb_gain_we_i (cb_we),
        .gain_wdata_i (wdata),
        .out_valid_o  (out_valid),
        .y_o          (y_o),
        .cr_o         (cr_o),
        .cb_o         (cb_o)
    );

    function automatic int ref_y(int l);
        int v = (l * 224 + 16 * 1024 + 512) >>> 10;
        if (v < 16) v = 16;
        if (v > 235) v = 235;
        return v;
    endfunction

    function automatic int ref_c(int d, int g, bit tw);
        longint p = longint'(d) * longint'(g) * 224;
        int v = int'((p + 131072) >>> 18);
        if (v > 112) v = 112;
        if (v < -112) v = -112;
        return tw ? (v & 255) : (v + 128);
    endfunction

    // Behavioural reference: gains, two-deep queue of expected words.
    int  g_cr, g_cb;
    int  p1_y, p1_cr, p1_cb, p2_y, p2_cr, p2_cb;
    bit  p1_v, p2_v, p1_tw, p2_tw;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_cr <= 183; g_cb <= 144;
            p1_v <= 0; p2_v <= 0; p1_tw <= 0; p2_tw <= 0;
            p1_y <= 0; p1_cr <= 0; p1_cb <= 0;
            p2_y <= 0; p2_cr <= 0; p2_cb <= 0;
        end else begin
            p2_v <= p1_v;
            if (p1_v) begin
                p2_y <= p1_y; p2_cr <= p1_cr; p2_cb <= p1_cb; p2_tw <= p1_tw;
            end
            p1_v <= in_valid;
            if (in_valid) begin
                p1_y  <= ref_y(int'(luma));
                p1_cr <= ref_c(int'(rmy), g_cr, fmt);
                p1_cb <= ref_c(int'(bmy), g_cb, fmt);
                p1_tw <= fmt;
            end
            if (cr_we) g_cr <= int'(wdata);
            if (cb_we) g_cb <= int'(wdata);
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8", "valid", int'(out_valid), int'(p2_v));
            check(p2_v ? "R1" : "R9", "y", int'(y_o), p2_y);
            check(p2_v ? (p2_tw ? "R6" : "R2") : "R9", "cr", int'(cr_o), p2_cr);
            check(p2_v ? (p2_tw ? "R6" : "R3") : "R9", "cb", int'(cb_o), p2_cb);
        end
    end

    task automatic push(int l, int r, int b, bit tw);
        @(negedge clk);
        in_valid = 1; luma = 12'(l); rmy = 12'(r); bmy = 12'(b); fmt = tw;
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
    endtask

    task automatic write_gain(bit to_cr, int val);
        @(negedge clk);
        cr_we = to_cr; cb_we = !to_cr; wdata = 9'(val);
        @(negedge clk);
        cr_we = 0; cb_we = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "reset valid", int'(out_valid), 0);
        check("R9", "reset y", int'(y_o), 0);
        check("R9", "reset cr", int'(cr_o), 0);
        check("R9", "reset cb", int'(cb_o), 0);
        rst_n = 1;

        // R4: default weights
        push(512, 512, 512, 0);
        check("R4", "y", int'(y_o), 128);
        check("R4", "cr", int'(cr_o), 208);
        check("R4", "cb", int'(cb_o), 191);

        // R5: independent weights
        write_gain(1, 256);
        push(512, 512, 512, 0);
        check("R5", "cr after cr write", int'(cr_o), 240);
        check("R5", "cb after cr write", int'(cb_o), 191);
        write_gain(0, 0);
        push(512, 512, 512, 0);
        check("R5", "cr after cb write", int'(cr_o), 240);
        check("R5", "cb after cb write", int'(cb_o), 128);

        // R6: two's complement, negative clamp edge
        push(0, -512, 512, 1);
        check("R6", "cr twos", int'(cr_o), 144);
        check("R6", "cb twos", int'(cb_o), 0);

        // R1: luma clamps
        push(2047, 0, 0, 0);
        check("R1", "y high clamp", int'(y_o), 235);
        push(-2048, 0, 0, 0);
        check("R1", "y low clamp", int'(y_o), 16);

        // R7: back-to-back samples in different modes
        @(negedge clk);
        in_valid = 1; luma = 12'(0); rmy = 12'(512); bmy = 12'(0); fmt = 0;
        @(negedge clk);
        fmt = 1;
        @(negedge clk);
        in_valid = 0;
        check("R7", "cr offset sample", int'(cr_o), 240);
        @(negedge clk);
        check("R7", "cr twos sample", int'(cr_o), 112);

        // Random stream with extremes, gain writes and format flips
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 3) != 0);
            luma = 12'($urandom_range(0, 4095));
            rmy  = 12'($urandom_range(0, 4095));
            bmy  = 12'($urandom_range(0, 4095));
            if ($urandom_range(0, 7) == 0) fmt = ~fmt;
            cr_we = ($urandom_range(0, 49) == 0);
            cb_we = ($urandom_range(0, 49) == 0);
            wdata = 9'($urandom_range(0, 511));
        end
        @(negedge clk);
        in_valid = 0; cr_we = 0; cb_we = 0;
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule